// File: doc/BRIEF.md
# Dual-Port Spin-Lock Word Memory

This block is a small word memory shared by two requesters. Each requester can read a word, write a word, or perform an atomic test-and-set. A test-and-set hands back the word's previous contents and leaves the word holding 1. No other access to that word can fall between the read and the write-back. Software uses the returned value as a spin-lock result: 0 means the lock was free and is now owned, and 1 means somebody else owns it. A plain write of 0 releases the lock.

While a test-and-set is in flight, the memory remembers its target address. If the other requester attempts a test-and-set on that same word, it is refused with a one-cycle busy pulse and nothing is done on its behalf; the requester has to try again later. If the other requester makes a plain read or write to that word, the access is held back until the test-and-set finishes. Test-and-sets to different words run side by side without interference.

Handshake: a requester raises its request with the operation, address and write data, and holds all of them steady. It keeps the request up until it sees either the done strobe or the busy strobe, and drops it in the following cycle. Operation codes are 2'b00 read, 2'b01 write and 2'b10 test-and-set; 2'b11 behaves as a read.

Top module: `tas_lock_mem`

## Requirements
- R1: After reset every word reads 0, and neither port shows done or busy until it is given a request.
- R2: A read returns the addressed word with done one cycle after acceptance. A write stores its data with done one cycle after acceptance. An accepted plain access therefore shows done at the first sample after the issuing edge (latency 1).
- R3: A test-and-set (code 2'b10) returns the word's previous value and leaves the word equal to 1. Its done arrives two cycles after acceptance (latency 2: a read cycle, then a write-back cycle).
- R4: A test-and-set that returns 0 has acquired the lock, and a later test-and-set returns 1 until a plain write of 0 to that word releases it.
- R5: A test-and-set from one port to the address of the other port's in-flight test-and-set is answered by busy. Busy lasts exactly one cycle, appears in place of done, and never appears together with done.
- R6: A refused test-and-set is not queued. It never changes the word, either at the time of the refusal or afterwards.
- R7: When both ports issue a test-and-set to the same address in the same cycle, port 0 completes it and port 1 gets busy at latency 1.
- R8: Test-and-sets on the two ports to different addresses in the same cycle both complete at latency 2 with no busy.
- R9: A plain access to a word held by the other port's test-and-set is stalled until that test-and-set's done cycle is over. A write of 0 issued during the test-and-set therefore takes effect after the write-back, with latency 3 when issued one cycle after the test-and-set.
- R10: When port 0 starts a plain access and port 1 starts any access to the same address in the same cycle, port 1 is held for one cycle, so port 0's access takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_req | input | 1 | Port 0 request, held until done or busy |
| p0_op | input | 2 | Port 0 operation code |
| p0_addr | input | 4 | Port 0 word address |
| p0_wdata | input | 8 | Port 0 write data |
| p0_rdata | output | 8 | Port 0 read / previous value, valid with done |
| p0_done | output | 1 | Port 0 completion strobe |
| p0_busy | output | 1 | Port 0 refusal strobe |
| p1_req | input | 1 | Port 1 request, held until done or busy |
| p1_op | input | 2 | Port 1 operation code |
| p1_addr | input | 4 | Port 1 word address |
| p1_wdata | input | 8 | Port 1 write data |
| p1_rdata | output | 8 | Port 1 read / previous value, valid with done |
| p1_done | output | 1 | Port 1 completion strobe |
| p1_busy | output | 1 | Port 1 refusal strobe |

## Verification
The first pattern is a seeded random series of single-port operations. It is compared against a bench-side memory model, which separates correct read, write and test-and-set data from wrong data, and it also checks that the 1-cycle and 2-cycle latencies are right. Random paired operations on distinct addresses confirm that the ports do not disturb each other when they do not collide. Directed collisions then separate the outcomes that the word value and latency reveal. A same-cycle test-and-set pair separates arbitration from silent serialization. A test-and-set one cycle behind another separates in-flight address tracking from no tracking. A write of 0 racing a test-and-set separates stalling from an interleaved write. A refused request followed by a release separates a dropped request from a queued one.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_TAS   = 2'b10,
    OP_RSVD  = 2'b11
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_TAS_DONE,
    ST_PLAIN_DONE,
    ST_REFUSED
  } port_state_e;
endpackage

// File: rtl/tas_word_array.sv
module tas_word_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    wr_en,
  input  logic [1:0][ADDR_W-1:0]        wr_addr,
  input  logic [1:0][DATA_W-1:0]        wr_data,
  input  logic [1:0]                    set_en,
  input  logic [1:0][ADDR_W-1:0]        set_addr,
  input  logic [1:0][ADDR_W-1:0]        rd_addr,
  output logic [1:0][DATA_W-1:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic              upd;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] val_q;

    always_comb begin
      upd = 1'b0;
      nxt = val_q;
      for (int k = 0; k < 2; k++) begin
        if (wr_en[k] && (wr_addr[k] == ADDR_W'(w))) begin
          upd = 1'b1;
          nxt = wr_data[k];
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (set_en[k] && (set_addr[k] == ADDR_W'(w))) begin
          upd = 1'b1;
          nxt = DATA_W'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (upd) begin
        val_q <= nxt;
      end
    end

    assign words[w] = val_q;
  end

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      rd_data[k] = words[rd_addr[k]];
    end
  end
endmodule

// File: rtl/tas_conflict_guard.sv
module tas_conflict_guard #(
  parameter int ADDR_W = 4
) (
  input  logic [1:0]             req,
  input  logic [1:0][1:0]        op,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0]             idle,
  input  logic [1:0]             lock_vld,
  input  logic [1:0][ADDR_W-1:0] lock_addr,
  output logic [1:0]             stall,
  output logic [1:0]             refuse
);
  import tas_lock_pkg::*;

  logic hit0, hit1, go0, same1, tas0, tas1;

  always_comb begin
    tas0  = (op[0] == OP_TAS);
    tas1  = (op[1] == OP_TAS);
    hit0  = lock_vld[1] && (lock_addr[1] == addr[0]);
    hit1  = lock_vld[0] && (lock_addr[0] == addr[1]);
    go0   = req[0] && idle[0] && !hit0;
    same1 = go0 && (addr[0] == addr[1]);

    refuse[0] = tas0 && hit0;
    stall[0]  = !tas0 && hit0;
    refuse[1] = tas1 && (hit1 || (same1 && tas0));
    stall[1]  = !refuse[1] && (hit1 || same1);
  end
endmodule

// File: rtl/tas_port_ctrl.sv
module tas_port_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stall,
  input  logic              refuse,
  input  logic [DATA_W-1:0] rd_word,
  output logic              idle,
  output logic              start,
  output logic              lock_vld,
  output logic [ADDR_W-1:0] lock_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              set_en,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy
);
  import tas_lock_pkg::*;

  port_state_e       state_q, state_d;
  logic [ADDR_W-1:0] lock_addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              is_tas;
  logic              cap_lock;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    is_tas   = (op == OP_TAS);
    start    = idle && req && !stall && !refuse;
    cap_lock = start && is_tas;
    wr_en    = start && (op == OP_WRITE);
    wr_data  = wdata;
    set_en   = (state_q == ST_WBACK);
    lock_vld = (state_q == ST_WBACK) || (state_q == ST_TAS_DONE);
    done     = (state_q == ST_TAS_DONE) || (state_q == ST_PLAIN_DONE);
    busy     = (state_q == ST_REFUSED);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (idle && req && refuse) begin
          state_d = ST_REFUSED;
        end else if (start) begin
          state_d = is_tas ? ST_WBACK : ST_PLAIN_DONE;
        end
      end
      ST_WBACK:      state_d = ST_TAS_DONE;
      ST_TAS_DONE:   state_d = ST_IDLE;
      ST_PLAIN_DONE: state_d = ST_IDLE;
      ST_REFUSED:    state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_addr_q <= '0;
    end else if (cap_lock) begin
      lock_addr_q <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (start) begin
      rdata_q <= rd_word;
    end
  end

  assign lock_addr = lock_addr_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/tas_lock_mem.sv
module tas_lock_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic [1:0]        p0_op,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  output logic              p0_done,
  output logic              p0_busy,
  input  logic              p1_req,
  input  logic [1:0]        p1_op,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              p1_done,
  output logic              p1_busy
);
  localparam int NPORT = 2;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NPORT-1:0]             req_v, idle_v, start_v, stall_v, refuse_v;
  logic [NPORT-1:0]             lock_vld_v, wr_en_v, set_en_v, done_v, busy_v;
  logic [NPORT-1:0][1:0]        op_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v, lock_addr_v;
  logic [NPORT-1:0][DATA_W-1:0] wdata_v, wr_data_v, rd_word_v, rdata_v;

  assign req_v   = {p1_req, p0_req};
  assign op_v    = {p1_op, p0_op};
  assign addr_v  = {p1_addr, p0_addr};
  assign wdata_v = {p1_wdata, p0_wdata};

  tas_conflict_guard #(.ADDR_W(ADDR_W)) u_guard (
    .req       (req_v),
    .op        (op_v),
    .addr      (addr_v),
    .idle      (idle_v),
    .lock_vld  (lock_vld_v),
    .lock_addr (lock_addr_v),
    .stall     (stall_v),
    .refuse    (refuse_v)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    tas_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .req       (req_v[g]),
      .op        (op_v[g]),
      .addr      (addr_v[g]),
      .wdata     (wdata_v[g]),
      .stall     (stall_v[g]),
      .refuse    (refuse_v[g]),
      .rd_word   (rd_word_v[g]),
      .idle      (idle_v[g]),
      .start     (start_v[g]),
      .lock_vld  (lock_vld_v[g]),
      .lock_addr (lock_addr_v[g]),
      .wr_en     (wr_en_v[g]),
      .wr_data   (wr_data_v[g]),
      .set_en    (set_en_v[g]),
      .rdata     (rdata_v[g]),
      .done      (done_v[g]),
      .busy      (busy_v[g])
    );
  end

  tas_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (wr_en_v),
    .wr_addr  (addr_v),
    .wr_data  (wr_data_v),
    .set_en   (set_en_v),
    .set_addr (lock_addr_v),
    .rd_addr  (addr_v),
    .rd_data  (rd_word_v)
  );

  assign p0_rdata = rdata_v[0];
  assign p1_rdata = rdata_v[1];
  assign p0_done  = done_v[0];
  assign p1_done  = done_v[1];
  assign p0_busy  = busy_v[0];
  assign p1_busy  = busy_v[1];
endmodule

// File: rtl/tas_lock_mem_chk.sv
module tas_lock_mem_chk #(
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           start,
  input logic [1:0][1:0]      op,
  input logic [1:0]           done,
  input logic [1:0]           busy,
  input logic [1:0]           lock_vld,
  input logic [1:0][ADDR_W-1:0] lock_addr,
  input logic [1:0]           wr_en,
  input logic [1:0][ADDR_W-1:0] addr
);
  AST_P0_DONE_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done[0] && busy[0])); // R5
  AST_P1_DONE_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done[1] && busy[1])); // R5
  AST_P0_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] |=> !busy[0]); // R5
  AST_P1_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] |=> !busy[1]); // R5
  AST_P0_TAS_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start[0] && op[0] == 2'b10) |=> (!done[0] ##1 done[0])); // R3
  AST_P1_TAS_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start[1] && op[1] == 2'b10) |=> (!done[1] ##1 done[1])); // R3
  AST_P0_PLAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start[0] && op[0] != 2'b10) |=> done[0]); // R2
  AST_P1_PLAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start[1] && op[1] != 2'b10) |=> done[1]); // R2
  AST_LOCKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vld[0] && lock_vld[1]) |-> (lock_addr[0] != lock_addr[1])); // R7
  AST_P1_NO_WRITE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[1] && lock_vld[0]) |-> (addr[1] != lock_addr[0])); // R9
  AST_P0_NO_WRITE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && lock_vld[1]) |-> (addr[0] != lock_addr[1])); // R9
endmodule

bind tas_lock_mem tas_lock_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .start     (start_v),
  .op        (op_v),
  .done      (done_v),
  .busy      (busy_v),
  .lock_vld  (lock_vld_v),
  .lock_addr (lock_addr_v),
  .wr_en     (wr_en_v),
  .addr      (addr_v)
);

// File: tb/sim_tas_lock_mem.sv
`timescale 1ns/1ps
module sim_tas_lock_mem;
  logic clk, rst_n;
  logic p0_req, p1_req, p0_done, p1_done, p0_busy, p1_busy;
  logic [1:0] p0_op, p1_op;
  logic [3:0] p0_addr, p1_addr;
  logic [7:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];

  tas_lock_mem u0 (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_op(p0_op), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
    .p0_rdata(p0_rdata), .p0_done(p0_done), .p0_busy(p0_busy),
    .p1_req(p1_req), .p1_op(p1_op), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_rdata(p1_rdata), .p1_done(p1_done), .p1_busy(p1_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [1:0] op);
    return (op == 2'b10) ? 2 : 1;
  endfunction

  task automatic run_op(input int p, input logic [1:0] op, input logic [3:0] a,
                        input logic [7:0] wd, output logic [7:0] rd,
                        output logic bz, output int lat);
    logic d;
    if (p == 0) begin
      p0_req = 1'b1; p0_op = op; p0_addr = a; p0_wdata = wd;
    end else begin
      p1_req = 1'b1; p1_op = op; p1_addr = a; p1_wdata = wd;
    end
    lat = 0;
    d = 1'b0;
    bz = 1'b0;
    while (!d && !bz && lat < 50) begin
      @(negedge clk);
      lat++;
      d  = (p == 0) ? p0_done : p1_done;
      bz = (p == 0) ? p0_busy : p1_busy;
    end
    rd = (p == 0) ? p0_rdata : p1_rdata;
    if (p == 0) p0_req = 1'b0; else p1_req = 1'b0;
  endtask

  task automatic checked_op(input int p, input logic [1:0] op, input logic [3:0] a,
                            input logic [7:0] wd, input string tag);
    logic [7:0] rd;
    logic bz;
    int lat;
    logic [7:0] old;
    old = model[a];
    run_op(p, op, a, wd, rd, bz, lat);
    check(!bz && lat == exp_latency(op), {tag, " latency"}, lat, exp_latency(op));
    if (op != 2'b01) check(rd == old, {tag, " data"}, rd, old);
    if (op == 2'b01) model[a] = wd;
    if (op == 2'b10) model[a] = 8'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r0, r1;
    logic b0, b1;
    int l0, l1;
    void'($urandom(32'd5150));
    p0_req = 0; p1_req = 0; p0_op = 0; p1_op = 0;
    p0_addr = 0; p1_addr = 0; p0_wdata = 0; p1_wdata = 0;
    for (int i = 0; i < 16; i++) model[i] = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle strobes and cleared words
    check(!p0_done && !p0_busy && !p1_done && !p1_busy, "R1 strobes idle",
          {p0_done, p0_busy, p1_done, p1_busy}, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      checked_op(i % 2, 2'b00, 4'(i), 8'd0, "R1 reset word");
    end

    // R2/R3 random single-port traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      @(negedge clk);
      checked_op(int'($urandom_range(0, 1)), op, 4'($urandom_range(0, 15)),
                 8'($urandom), (op == 2'b10) ? "R3 random tas" : "R2 random plain");
    end

    // R8: random pairs on distinct addresses
    for (int i = 0; i < 60; i++) begin
      logic [3:0] a0, a1;
      logic [1:0] o0, o1;
      a0 = 4'($urandom_range(0, 15));
      a1 = a0 + 4'($urandom_range(1, 15));
      o0 = (i % 3 == 0) ? 2'b10 : 2'($urandom_range(0, 3));
      o1 = (i % 3 == 0) ? 2'b10 : 2'($urandom_range(0, 3));
      @(negedge clk);
      fork
        checked_op(0, o0, a0, 8'($urandom), "R8 pair p0");
        checked_op(1, o1, a1, 8'($urandom), "R8 pair p1");
      join
    end

    // R4: acquire, held, release, reacquire on word 3
    @(negedge clk); checked_op(0, 2'b01, 4'd3, 8'd0, "R4 clear");
    @(negedge clk); run_op(0, 2'b10, 4'd3, 8'd0, r0, b0, l0);
    model[3] = 8'd1;
    check(r0 == 8'd0, "R4 acquire", r0, 0);
    @(negedge clk); run_op(1, 2'b10, 4'd3, 8'd0, r1, b1, l1);
    check(r1 == 8'd1 && !b1, "R4 held", r1, 1);
    @(negedge clk); checked_op(0, 2'b01, 4'd3, 8'd0, "R4 release");
    @(negedge clk); run_op(1, 2'b10, 4'd3, 8'd0, r1, b1, l1);
    model[3] = 8'd1;
    check(r1 == 8'd0, "R4 reacquire", r1, 0);

    // R7 + R6: same-cycle tas on word 5, then release; refused one must not reappear
    @(negedge clk); checked_op(0, 2'b01, 4'd5, 8'd0, "R7 prep");
    @(negedge clk);
    fork
      run_op(0, 2'b10, 4'd5, 8'd0, r0, b0, l0);
      run_op(1, 2'b10, 4'd5, 8'd0, r1, b1, l1);
    join
    check(!b0 && l0 == 2 && r0 == 8'd0, "R7 port0 wins", l0, 2);
    check(b1 && l1 == 1, "R7 port1 busy", l1, 1);
    @(negedge clk); checked_op(0, 2'b01, 4'd5, 8'd0, "R6 release");
    model[5] = 8'd0;
    repeat (4) @(negedge clk);
    checked_op(1, 2'b00, 4'd5, 8'd0, "R6 refused not queued");

    // R5: tas one cycle behind on word 7
    @(negedge clk); checked_op(1, 2'b01, 4'd7, 8'd0, "R5 prep");
    @(negedge clk);
    fork
      run_op(1, 2'b10, 4'd7, 8'd0, r1, b1, l1);
      begin @(negedge clk); run_op(0, 2'b10, 4'd7, 8'd0, r0, b0, l0); end
    join
    check(!b1 && r1 == 8'd0, "R5 holder done", r1, 0);
    check(b0 && l0 == 1, "R5 busy pulse", l0, 1);
    @(negedge clk);
    check(!p0_busy && !p0_done, "R5 busy one cycle", p0_busy, 0);
    model[7] = 8'd1;

    // R9: write of 0 during tas on word 9 stalls until after write-back
    @(negedge clk); checked_op(0, 2'b01, 4'd9, 8'd0, "R9 prep");
    @(negedge clk);
    fork
      run_op(0, 2'b10, 4'd9, 8'd0, r0, b0, l0);
      begin @(negedge clk); run_op(1, 2'b01, 4'd9, 8'd0, r1, b1, l1); end
    join
    check(r0 == 8'd0 && l0 == 2, "R9 tas result", r0, 0);
    check(!b1 && l1 == 3, "R9 write stalled", l1, 3);
    model[9] = 8'd0;
    @(negedge clk); checked_op(0, 2'b00, 4'd9, 8'd0, "R9 final word");

    // R10: port 0 plain write and port 1 tas same cycle on word 11
    @(negedge clk); checked_op(1, 2'b01, 4'd11, 8'd1, "R10 prep");
    @(negedge clk);
    fork
      run_op(0, 2'b01, 4'd11, 8'd0, r0, b0, l0);
      run_op(1, 2'b10, 4'd11, 8'd0, r1, b1, l1);
    join
    check(l0 == 1 && !b0, "R10 port0 first", l0, 1);
    check(!b1 && l1 == 3 && r1 == 8'd0, "R10 port1 sees write", r1, 0);
    model[11] = 8'd1;
    @(negedge clk); checked_op(1, 2'b00, 4'd11, 8'd0, "R10 final word");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule